// File: doc/BRIEF.md
# Banked EPROM Read Sequencer

This block sits on the host side of a bank of parallel EPROM devices that share one data bus. A requester gives it a read address on a valid/ready handshake. The sequencer splits the address into a device index and a word address. It pulls low the chip enable of exactly one device and leaves every other device deselected, which holds them in low-power standby. It drives a single output enable that is common to the whole bank.

All device timing is expressed as whole clock cycles, rounded up from the datasheet times of the chosen speed grade. The parameters cover address access, chip-enable access, output-enable access and output float time. The output enable is held back so that it falls only the output-enable access time before the capture edge. The data bus is sampled on the edge where every access time has elapsed, and the byte is returned with a one-cycle valid pulse. The sequencer then keeps the whole bank released for the float time, so that the device just read can go high-impedance before any device is enabled again.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, req_ready_o is 1, every bit of mem_ce_no is 1, mem_oe_no is 1 and rsp_valid_o is 0.
- R2: The device index is req_addr_i[ADDR_W-1:DEV_AW]. For a read of device k, bit k of mem_ce_no is 0 and all other bits are 1. No two bits are ever 0 together.
- R3: mem_oe_no is 0 only while a chip enable is 0. It is 0 exactly in the last T_OE cycles of the access window.
- R4: mem_addr_o carries req_addr_i[DEV_AW-1:0] from the first cycle of the access window. It stays unchanged for as long as the chip enable is 0.
- R5: The access window begins in the cycle after acceptance and lasts W = max(T_ACC, T_CE, T_OE) cycles, with chip enable low throughout. mem_data_i is captured on the clock edge that ends the window.
- R6: rsp_valid_o is 1 for exactly one cycle, the cycle after the window ends, and rsp_data_o then holds the captured byte.
- R7: A request is accepted only in a cycle where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after acceptance until the float interval ends. A req_valid_i that is 1 while req_ready_o is 0 has no effect on any output.
- R8: After chip enable and output enable rise, all chip enables and the output enable stay 1 for at least T_DF cycles before any device is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | ADDR_W | Device index (upper bits) and word address |
| req_ready_o | output | 1 | Sequencer idle, request may be accepted |
| mem_addr_o | output | DEV_AW | Shared word address to the bank |
| mem_ce_no | output | N_DEV | Per-device chip enable, active low |
| mem_oe_no | output | 1 | Common output enable, active low |
| mem_data_i | input | DW | Shared data bus from the bank |
| rsp_valid_o | output | 1 | One-cycle pulse with returned data |
| rsp_data_o | output | DW | Captured read data |

## Verification
A wrong state or count in this block shows at the ports quickly. Chip enables appear on the wrong device, the output enable edges move, or req_ready_o returns early or late. The per-cycle reference model sees any of these in the same cycle as the fault. The bench also models the devices: the bus carries the true byte only when address, chip-enable and output-enable ages all meet their access times, and carries the inverted byte otherwise. An output enable that falls late, or a capture that is one cycle early, therefore returns corrupted data in the rsp_valid_o cycle of that same read.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int unsigned N_DEV = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_DEV-1:0] ce_no
);

  for (genvar g = 0; g < N_DEV; g++) begin : g_ce
    assign ce_no[g] = !(en_i && (sel_i == SEL_W'(g)));
  end

endmodule

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else              count_o <= count_o + CNT_W'(1);
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned DEV_AW = 15,
  parameter int unsigned DW     = 8,
  parameter int unsigned T_ACC  = 5,
  parameter int unsigned T_CE   = 4,
  parameter int unsigned T_OE   = 2,
  parameter int unsigned T_DF   = 3,
  localparam int unsigned SEL_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int unsigned ADDR_W = DEV_AW + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [DEV_AW-1:0] mem_addr_o,
  output logic [N_DEV-1:0]  mem_ce_no,
  output logic              mem_oe_no,
  input  logic [DW-1:0]     mem_data_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_data_o
);

  localparam int unsigned WAIT_RAW = max3(T_ACC, T_CE, T_OE);
  localparam int unsigned WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int unsigned OE_START = (T_OE >= WAIT_CYC) ? 0 : WAIT_CYC - T_OE;
  localparam int unsigned DF_LAST  = (T_DF > 0) ? T_DF - 1 : 0;
  localparam int unsigned CNT_W    = $clog2(max2(WAIT_CYC, T_DF) + 1);

  rd_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt;
  logic [SEL_W-1:0]  dev_q;
  logic [DEV_AW-1:0] addr_q;
  logic              accept, last_acc, last_flt, timer_clr;

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign last_acc = (state_q == ST_ACCESS) && (cnt == CNT_W'(WAIT_CYC - 1));
  assign last_flt = (state_q == ST_FLOAT) && (cnt == CNT_W'(DF_LAST));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ACCESS;
      ST_ACCESS: if (last_acc) state_d = (T_DF == 0) ? ST_IDLE : ST_FLOAT;
      ST_FLOAT:  if (last_flt) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign timer_clr = (state_q == ST_IDLE) || (state_d != state_q);

  eprom_rd_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (timer_clr),
    .count_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      dev_q  <= req_addr_i[ADDR_W-1:DEV_AW];
      addr_q <= req_addr_i[DEV_AW-1:0];
    end
  end

  eprom_ce_decode #(.N_DEV(N_DEV), .SEL_W(SEL_W)) i_decode (
    .en_i  (state_q == ST_ACCESS),
    .sel_i (dev_q),
    .ce_no (mem_ce_no)
  );

  // output enable held back so it falls T_OE cycles before capture
  assign mem_oe_no  = !((state_q == ST_ACCESS) && (cnt >= CNT_W'(OE_START)));
  assign mem_addr_o = addr_q;
  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= last_acc;
      if (last_acc) rsp_data_o <= mem_data_i;
    end
  end

  assert_ce_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_ce_no));

  assert_oe_needs_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_ce_no != '1));

  assert_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_no != '1) |=> ((mem_ce_no == '1) || $stable(mem_addr_o)));

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_float_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLOAT) |-> ((mem_ce_no == '1) && mem_oe_no));

  assert_release_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_ce_no) != '1 && mem_ce_no == '1 && T_DF > 0) |=> (mem_ce_no == '1));

endmodule

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

  localparam int N_DEV = 4;
  localparam int DEV_AW = 15;
  localparam int DW = 8;
  localparam int T_ACC = 5;
  localparam int T_CE = 4;
  localparam int T_OE = 2;
  localparam int T_DF = 3;
  localparam int ADDR_W = DEV_AW + 2;
  localparam int W = (T_ACC > T_CE) ? ((T_ACC > T_OE) ? T_ACC : T_OE)
                                    : ((T_CE > T_OE) ? T_CE : T_OE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready;
  logic [DEV_AW-1:0] mem_addr;
  logic [N_DEV-1:0] mem_ce_n;
  logic mem_oe_n;
  logic [DW-1:0] mem_data = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eprom_rd_ctrl #(
    .N_DEV(N_DEV), .DEV_AW(DEV_AW), .DW(DW),
    .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)
  ) i_eprom_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_oe_no(mem_oe_n),
    .mem_data_i(mem_data), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  function automatic logic [7:0] dev_byte(int dev, logic [DEV_AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'(dev * 8'h35);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: phase counted from the edge that accepts a request
  bit act_r = 0;
  int ph = 0;
  int exp_dev = 0;
  logic [DEV_AW-1:0] exp_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      act_r = 0; ph = 0;
    end else begin
      bit rdy_now;
      rdy_now = !act_r || (ph >= W + T_DF);
      if (rdy_now && req_valid) begin
        act_r = 1; ph = 0;
        exp_dev = int'(req_addr[ADDR_W-1:DEV_AW]);
        exp_addr = req_addr[DEV_AW-1:0];
      end else if (act_r) ph++;
    end
  end

  // device bank model: true byte only once every access time is met
  int addr_age = 0, ce_age = 0, oe_age = 0, rel_age = 1000;
  logic [DEV_AW-1:0] prev_addr = '0;
  bit prev_sel = 0;

  always @(negedge clk) begin
    bit sel;
    int d;
    sel = (mem_ce_n != '1);
    addr_age = (mem_addr != prev_addr) ? 1 : addr_age + 1;
    prev_addr = mem_addr;
    ce_age = sel ? ce_age + 1 : 0;
    oe_age = !mem_oe_n ? oe_age + 1 : 0;
    d = 0;
    for (int i = 0; i < N_DEV; i++) if (!mem_ce_n[i]) d = i;
    if (sel && !prev_sel)
      chk(rel_age > T_DF, "R8 release gap", rel_age, T_DF + 1);
    rel_age = (sel || !mem_oe_n) ? 0 : rel_age + 1;
    prev_sel = sel;
    if (sel && addr_age >= T_ACC && ce_age >= T_CE && oe_age >= T_OE)
      mem_data <= dev_byte(d, mem_addr);
    else
      mem_data <= ~dev_byte(d, mem_addr);
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      logic [N_DEV-1:0] e_ce;
      bit e_oe, e_rv, e_rdy, in_win;
      in_win = act_r && ph < W;
      e_ce = in_win ? ~(N_DEV'(1) << exp_dev) : '1;
      e_oe = !(in_win && ph >= W - T_OE);
      e_rv = act_r && ph == W;
      e_rdy = !act_r || ph >= W + T_DF;
      if (!rst_n || !act_r) begin
        chk(mem_ce_n == e_ce && mem_oe_n == e_oe && rsp_valid == e_rv && req_ready == e_rdy,
            "R1 idle outputs", {mem_ce_n, mem_oe_n, rsp_valid, req_ready},
            {e_ce, e_oe, e_rv, e_rdy});
      end else begin
        chk(mem_ce_n == e_ce, "R2/R5 chip enable", mem_ce_n, e_ce);
        chk(mem_oe_n == e_oe, "R3 output enable", mem_oe_n, e_oe);
        chk(rsp_valid == e_rv, "R6 rsp valid", rsp_valid, e_rv);
        chk(req_ready == e_rdy, "R7 ready", req_ready, e_rdy);
        if (in_win) chk(mem_addr == exp_addr, "R4 address", mem_addr, exp_addr);
        if (e_rv)
          chk(rsp_data == dev_byte(exp_dev, exp_addr), "R5/R6 read data",
              rsp_data, dev_byte(exp_dev, exp_addr));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2: one read per device, valid held until accepted
    for (int k = 0; k < N_DEV; k++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr = {2'(k), 15'(16'h1234 + k * 16'h0777)};
      @(posedge clk);
      while (!req_ready) @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (W + T_DF + 2) @(negedge clk);
    end
    // R7/R8: back-to-back requests with valid held high
    req_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin
      req_addr = {2'(k % N_DEV), 15'(k * 16'h0913)};
      @(posedge clk);
      while (!req_ready) @(posedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    // R7: pseudo-random valid toggling, including pulses while busy
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid = lfsr[0] & lfsr[3];
      req_addr = {lfsr[9:8], lfsr[14:0] ^ 15'(n)};
    end
    req_valid = 1'b0;
    repeat (W + T_DF + 4) @(negedge clk);
    // R1: reset in the middle of a read
    req_valid = 1'b1;
    req_addr = {2'd2, 15'h7FFF};
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule